// File: doc/BRIEF.md
# Register ALU stage with NZCV flags

This block is the execute stage for the register-to-register arithmetic and logic group of a compact 16-bit instruction encoding that works on 32-bit data. Each cycle it takes a 4-bit operation code, the destination operand, the source operand and a valid strobe. Using the carry held in its own flag register, it computes a result. It drives that result with a write-enable for the register file, and on the clock edge it updates the negative, zero, carry and overflow flags.

All sixteen operation codes are handled. Compare and test forms update flags but leave the destination alone. Logical forms and the multiply keep carry and overflow. Every subtraction stores carry as NOT-borrow. The three shifts and the rotate take their amount from the low byte of the source operand. Multiply finishes in one cycle.

Top module: `regalu_stage`

## Requirements
- R1: Operation codes 0 (AND), 1 (XOR), 12 (OR), 14 (destination AND NOT source) and 15 (NOT source) drive the corresponding bitwise value on `result_o`.
- R2: Codes 0, 1, 12, 13, 14 and 15 update only N and Z; C and V keep their previous values.
- R3: Code 5 produces dst + src + C; C becomes the unsigned carry out of bit 31, and V becomes the signed overflow.
- R4: Code 6 produces dst − src − (NOT C). Code 10 computes dst − src. For both, C = 1 means no borrow occurred, and V is the signed overflow of the subtraction.
- R5: Code 9 produces 0 − src and sets all four flags as a subtraction from zero (src = 0 gives C = 1; src = 0x80000000 gives V = 1).
- R6: Codes 8 (AND), 10 (subtract) and 11 (add) update the flags but hold `wr_en_o` low; every other code drives `wr_en_o` high while `valid_i` is high.
- R7: Codes 2 (shift left) and 3 (logical shift right) shift by `src_i[7:0]`. Amounts 1 to 31 set C to the last bit shifted out. An amount of 32 gives result 0, with C = bit 0 for a left shift and C = bit 31 for a right shift. Amounts above 32 give result 0 and C = 0.
- R8: Code 4 (arithmetic shift right) with an amount of 32 or more fills the result with bit 31 of dst and sets C to that bit.
- R9: Code 7 rotates dst right by `src_i[4:0]`. When the amount is nonzero, C becomes result bit 31; this includes a nonzero amount whose low five bits are zero, which leaves the value unchanged.
- R10: Every valid operation sets Z when the 32-bit result is zero and sets N to result bit 31. Shifts and the rotate leave V unchanged. A shift amount of 0 leaves the value and C unchanged.
- R11: Reset clears all flags. The flags change only on a clock edge where `valid_i` is high. `flags_o` is {N, Z, C, V} with N in bit 3 and V in bit 0.
- R12: Code 13 produces the low 32 bits of dst × src within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | Operation is valid this cycle |
| op_i | input | 4 | Operation code |
| dst_i | input | 32 | Destination operand (first operand) |
| src_i | input | 32 | Source operand / shift amount in bits 7:0 |
| result_o | output | 32 | Computed value, including for compare and test forms |
| wr_en_o | output | 1 | Write-back enable for the destination register |
| flags_o | output | 4 | Registered flags {N, Z, C, V} |

## Verification
The hardest cases to reach from the ports are shift amounts of exactly 32, of just over 32, and of a multiple of 32 for the rotate. Random 32-bit source operands almost never land on those low-byte values. The stimulus therefore draws half its shift amounts from a small set of edge values (0, 1, 31, 32, 33, 64, 255). Carry-dependent add and subtract also need a known carry on entry, so directed sequences first set C with a compare and then issue the carry-consuming operation. A cycle-accurate model in the bench tracks the flags across every valid and idle cycle.

// File: rtl/regalu_pkg.sv
package regalu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'h0,
    OP_EOR  = 4'h1,
    OP_SHL  = 4'h2,
    OP_SHR  = 4'h3,
    OP_SAR  = 4'h4,
    OP_ADDC = 4'h5,
    OP_SUBC = 4'h6,
    OP_ROTR = 4'h7,
    OP_TEST = 4'h8,
    OP_NEG  = 4'h9,
    OP_CMPS = 4'hA,
    OP_CMPA = 4'hB,
    OP_IOR  = 4'hC,
    OP_MULT = 4'hD,
    OP_CLRB = 4'hE,
    OP_NOTM = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;

  typedef enum logic [1:0] {
    FK_LOGIC = 2'd0,
    FK_ARITH = 2'd1,
    FK_SHIFT = 2'd2
  } flag_kind_e;

  typedef enum logic [1:0] {
    SEL_LOGIC = 2'd0,
    SEL_ADDER = 2'd1,
    SEL_SHIFT = 2'd2
  } res_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/regalu_rst_sync.sv
module regalu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/regalu_shift.sv
module regalu_shift
  import regalu_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]     val_i,
  input  logic [AMT_W-1:0] amt_i,
  input  shift_kind_e      kind_i,
  input  logic             cin_i,
  output logic [W-1:0]     res_o,
  output logic             cout_o
);
  localparam int RW = $clog2(W);

  logic [W:0]          lsl_ext;
  logic [W:0]          lsr_ext;
  logic signed [W:0]   asr_ext;
  logic [RW-1:0]       rot_amt;
  logic [2*W-1:0]      rot_dbl;
  logic [W-1:0]        rot_res;

  always_comb begin
    // left shift keeps the outgoing bit in the extra top position
    lsl_ext = {1'b0, val_i} << amt_i;
    // right shifts keep the outgoing bit in the extra bottom position
    lsr_ext = {val_i, 1'b0} >> amt_i;
    asr_ext = $signed({val_i, 1'b0}) >>> amt_i;
    rot_amt = amt_i[RW-1:0];
    rot_dbl = {val_i, val_i} >> rot_amt;
    rot_res = rot_dbl[W-1:0];
  end

  always_comb begin
    res_o  = val_i;
    cout_o = cin_i;
    if (amt_i != '0) begin
      unique case (kind_i)
        SK_LSL: begin
          res_o  = lsl_ext[W-1:0];
          cout_o = lsl_ext[W];
        end
        SK_LSR: begin
          res_o  = lsr_ext[W:1];
          cout_o = lsr_ext[0];
        end
        SK_ASR: begin
          res_o  = asr_ext[W:1];
          cout_o = asr_ext[0];
        end
        SK_ROR: begin
          res_o  = rot_res;
          cout_o = rot_res[W-1];
        end
        default: begin
          res_o  = val_i;
          cout_o = cin_i;
        end
      endcase
    end
  end
endmodule

// File: rtl/regalu_adder.sv
module regalu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W:0] wide;

  always_comb begin
    wide   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    sum_o  = wide[W-1:0];
    cout_o = wide[W];
    ovf_o  = (a_i[W-1] == b_i[W-1]) && (wide[W-1] != a_i[W-1]);
  end
endmodule

// File: rtl/regalu_flags.sv
module regalu_flags
  import regalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  flag_kind_e   kind_i,
  input  logic [W-1:0] res_i,
  input  logic         add_c_i,
  input  logic         add_v_i,
  input  logic         sh_c_i,
  output nzcv_t        q_o
);
  nzcv_t q, d;

  always_comb begin
    d = q;
    if (en_i) begin
      d.n = res_i[W-1];
      d.z = (res_i == '0);
      unique case (kind_i)
        FK_ARITH: begin
          d.c = add_c_i;
          d.v = add_v_i;
        end
        FK_SHIFT: d.c = sh_c_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (en_i) q <= d;
  end

  assign q_o = q;

  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(q));

  a_r10_nz_from_result: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (q.z == ($past(res_i) == '0)) && (q.n == $past(res_i[W-1])));

  a_r2_logic_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && kind_i == FK_LOGIC |=> q.c == $past(q.c) && q.v == $past(q.v));

  a_r10_shift_keeps_v: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && kind_i == FK_SHIFT |=> q.v == $past(q.v));
endmodule

// File: rtl/regalu_stage.sv
module regalu_stage
  import regalu_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] dst_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [3:0]   flags_o
);
  logic        rst_s_n;
  alu_op_e     op;
  nzcv_t       flg;

  logic [W-1:0] add_a, add_b, add_sum;
  logic         add_ci, add_co, add_ov;
  logic [W-1:0] sh_res;
  logic         sh_co;
  shift_kind_e  sh_kind;
  logic [W-1:0] log_res;
  logic [W-1:0] mul_res;
  res_sel_e     sel;
  flag_kind_e   fkind;
  logic         writes;

  regalu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  assign op = alu_op_e'(op_i);

  // decode: operand routing for the shared adder, shifter kind, class
  always_comb begin
    add_a   = dst_i;
    add_b   = src_i;
    add_ci  = 1'b0;
    sh_kind = SK_LSL;
    sel     = SEL_LOGIC;
    fkind   = FK_LOGIC;
    writes  = 1'b1;
    mul_res = dst_i * src_i;
    log_res = dst_i & src_i;
    unique case (op)
      OP_AND:  log_res = dst_i & src_i;
      OP_EOR:  log_res = dst_i ^ src_i;
      OP_IOR:  log_res = dst_i | src_i;
      OP_CLRB: log_res = dst_i & ~src_i;
      OP_NOTM: log_res = ~src_i;
      OP_MULT: log_res = mul_res;
      OP_TEST: begin
        log_res = dst_i & src_i;
        writes  = 1'b0;
      end
      OP_SHL: begin sh_kind = SK_LSL; sel = SEL_SHIFT; fkind = FK_SHIFT; end
      OP_SHR: begin sh_kind = SK_LSR; sel = SEL_SHIFT; fkind = FK_SHIFT; end
      OP_SAR: begin sh_kind = SK_ASR; sel = SEL_SHIFT; fkind = FK_SHIFT; end
      OP_ROTR: begin sh_kind = SK_ROR; sel = SEL_SHIFT; fkind = FK_SHIFT; end
      OP_ADDC: begin
        add_ci = flg.c;
        sel = SEL_ADDER; fkind = FK_ARITH;
      end
      OP_SUBC: begin
        add_b  = ~src_i;
        add_ci = flg.c;
        sel = SEL_ADDER; fkind = FK_ARITH;
      end
      OP_CMPS: begin
        add_b  = ~src_i;
        add_ci = 1'b1;
        sel = SEL_ADDER; fkind = FK_ARITH; writes = 1'b0;
      end
      OP_CMPA: begin
        sel = SEL_ADDER; fkind = FK_ARITH; writes = 1'b0;
      end
      OP_NEG: begin
        add_a  = '0;
        add_b  = ~src_i;
        add_ci = 1'b1;
        sel = SEL_ADDER; fkind = FK_ARITH;
      end
      default: ;
    endcase
  end

  regalu_adder #(.W(W)) u_add (
    .a_i(add_a), .b_i(add_b), .cin_i(add_ci),
    .sum_o(add_sum), .cout_o(add_co), .ovf_o(add_ov));

  regalu_shift #(.W(W), .AMT_W(AMT_W)) u_shf (
    .val_i(dst_i), .amt_i(src_i[AMT_W-1:0]), .kind_i(sh_kind),
    .cin_i(flg.c), .res_o(sh_res), .cout_o(sh_co));

  always_comb begin
    unique case (sel)
      SEL_ADDER: result_o = add_sum;
      SEL_SHIFT: result_o = sh_res;
      default:   result_o = log_res;
    endcase
  end

  assign wr_en_o = valid_i & writes;

  regalu_flags #(.W(W)) u_flg (
    .clk(clk), .rst_n(rst_s_n), .en_i(valid_i), .kind_i(fkind),
    .res_i(result_o), .add_c_i(add_co), .add_v_i(add_ov), .sh_c_i(sh_co),
    .q_o(flg));

  assign flags_o = flg;

  a_r6_compare_no_write: assert property (@(posedge clk) disable iff (!rst_s_n)
    valid_i && (op_i == 4'h8 || op_i == 4'hA || op_i == 4'hB) |-> !wr_en_o);

  a_r4_compare_carry_is_no_borrow: assert property (@(posedge clk) disable iff (!rst_s_n)
    valid_i && op_i == 4'hA |=> flags_o[1] == ($past(dst_i) >= $past(src_i)));

  a_r10_zero_amount_passes: assert property (@(posedge clk) disable iff (!rst_s_n)
    valid_i && (op_i == 4'h2 || op_i == 4'h3 || op_i == 4'h4 || op_i == 4'h7)
      && src_i[AMT_W-1:0] == '0 |-> result_o == dst_i);

  a_r10_zero_amount_keeps_c: assert property (@(posedge clk) disable iff (!rst_s_n)
    valid_i && (op_i == 4'h2 || op_i == 4'h3 || op_i == 4'h4 || op_i == 4'h7)
      && src_i[AMT_W-1:0] == '0 |=> flags_o[1] == $past(flags_o[1]));

  a_r5_neg_zero_sets_c: assert property (@(posedge clk) disable iff (!rst_s_n)
    valid_i && op_i == 4'h9 && src_i == '0 |=> flags_o[1] && flags_o[2]);
endmodule

// File: tb/regalu_stage_tb.sv
module regalu_stage_tb;
  logic        clk;
  logic        rst_n;
  logic        valid_i;
  logic [3:0]  op_i;
  logic [31:0] dst_i, src_i;
  logic [31:0] result_o;
  logic        wr_en_o;
  logic [3:0]  flags_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [3:0] mflags;
  string      last_tag;

  regalu_stage u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .dst_i(dst_i), .src_i(src_i), .result_o(result_o),
    .wr_en_o(wr_en_o), .flags_o(flags_o));

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h0, 4'h1, 4'hC, 4'hE, 4'hF: return "R1";
      4'h2, 4'h3: return "R7";
      4'h4: return "R8";
      4'h5: return "R3";
      4'h6: return "R4";
      4'h7: return "R9";
      4'h8, 4'hA, 4'hB: return "R6";
      4'h9: return "R5";
      default: return "R12";
    endcase
  endfunction

  function automatic void model(input logic [3:0] op, input logic [31:0] d, s,
                                input logic [3:0] f, output logic [31:0] r,
                                output logic we, output logic [3:0] nf);
    logic c, v;
    int amt;
    longint sd, ud;
    c = f[1]; v = f[0]; we = 1'b1; amt = int'(s[7:0]); r = '0;
    case (op)
      4'h0: r = d & s;
      4'h1: r = d ^ s;
      4'hC: r = d | s;
      4'hE: r = d & ~s;
      4'hF: r = ~s;
      4'hD: r = d * s;
      4'h8: begin r = d & s; we = 1'b0; end
      4'h5, 4'hB: begin
        longint ci;
        ci = (op == 4'h5 && c) ? 1 : 0;
        ud = longint'(d) + longint'(s) + ci;
        sd = longint'($signed(d)) + longint'($signed(s)) + ci;
        r = ud[31:0]; c = ud[32];
        v = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
        if (op == 4'hB) we = 1'b0;
      end
      4'h6, 4'hA, 4'h9: begin
        longint bw, a_u, a_s;
        bw  = (op == 4'h6 && !c) ? 1 : 0;
        a_u = (op == 4'h9) ? 0 : longint'(d);
        a_s = (op == 4'h9) ? 0 : longint'($signed(d));
        ud = a_u - longint'(s) - bw;
        sd = a_s - longint'($signed(s)) - bw;
        r = ud[31:0];
        c = (a_u >= longint'(s) + bw);
        v = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
        if (op == 4'hA) we = 1'b0;
      end
      4'h2: begin
        if (amt == 0) r = d;
        else if (amt < 32) begin r = d << amt; c = d[32-amt]; end
        else if (amt == 32) begin r = 0; c = d[0]; end
        else begin r = 0; c = 0; end
      end
      4'h3: begin
        if (amt == 0) r = d;
        else if (amt < 32) begin r = d >> amt; c = d[amt-1]; end
        else if (amt == 32) begin r = 0; c = d[31]; end
        else begin r = 0; c = 0; end
      end
      4'h4: begin
        if (amt == 0) r = d;
        else if (amt < 32) begin r = $signed(d) >>> amt; c = d[amt-1]; end
        else begin r = {32{d[31]}}; c = d[31]; end
      end
      default: begin
        r = d;
        if (amt != 0) begin
          for (int i = 0; i < amt % 32; i++) r = {r[0], r[31:1]};
          c = r[31];
        end
      end
    endcase
    nf = {r[31], (r == 0), c, v};
  endfunction

  task automatic fail_line(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    errors++;
    $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
  endtask

  task automatic step(input logic v, input logic [3:0] op,
                      input logic [31:0] d, input logic [31:0] s);
    logic [31:0] r; logic we; logic [3:0] nf;
    @(negedge clk);
    checks++;
    if (flags_o !== mflags) fail_line(last_tag, "flags", {28'd0, flags_o}, {28'd0, mflags});
    valid_i = v; op_i = op; dst_i = d; src_i = s;
    #1;
    model(op, d, s, mflags, r, we, nf);
    if (v) begin
      checks++;
      if (result_o !== r) fail_line(tag_of(op), "result", result_o, r);
      checks++;
      if (wr_en_o !== we) fail_line("R6", "wr_en", {31'd0, wr_en_o}, {31'd0, we});
      mflags = nf;
      last_tag = (op == 4'hD) ? "R2" : "R10";
    end else begin
      checks++;
      if (wr_en_o !== 1'b0) fail_line("R11", "idle wr_en", {31'd0, wr_en_o}, 32'd0);
      last_tag = "R11";
    end
  endtask

  function automatic logic [31:0] pick_src();
    logic [7:0] edges [7] = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33, 8'd64, 8'd255};
    logic [31:0] s;
    s = $urandom;
    if ($urandom_range(1, 0) == 1) s[7:0] = edges[$urandom_range(6, 0)];
    return s;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; valid_i = 0; op_i = 0; dst_i = 0; src_i = 0;
    mflags = 4'h0; last_tag = "R11";
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    checks++; // R11 reset state
    if (flags_o !== 4'h0) fail_line("R11", "reset flags", {28'd0, flags_o}, 32'd0);

    // R1 logic forms, R2 C/V kept after a compare set them
    step(1, 4'hA, 32'h0000_0005, 32'h0000_0005);  // C=1 Z=1
    step(1, 4'h0, 32'hF0F0_1234, 32'h0FF0_FF00);
    step(1, 4'h1, 32'hFFFF_0000, 32'h00FF_FF00);
    step(1, 4'hC, 32'h8000_0000, 32'h0000_0001);
    step(1, 4'hE, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(1, 4'hF, 32'h0, 32'h0);
    // R12 multiply, R2 kept flags
    step(1, 4'hD, 32'h0001_0003, 32'h0002_0005);
    step(1, 4'hD, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R3 add with carry overflow
    step(1, 4'hA, 32'h9, 32'h1);                   // C=1
    step(1, 4'h5, 32'h7FFF_FFFF, 32'h0);
    step(1, 4'h5, 32'hFFFF_FFFF, 32'h1);
    // R4 subtract with carry, both carry states
    step(1, 4'hA, 32'h1, 32'h2);                   // C=0 borrow
    step(1, 4'h6, 32'h10, 32'h5);
    step(1, 4'h6, 32'h8000_0000, 32'h1);
    // R5 negate
    step(1, 4'h9, 32'h0, 32'h0);
    step(1, 4'h9, 32'h0, 32'h8000_0000);
    step(1, 4'h9, 32'h0, 32'h1);
    // R6 compare-negative, test
    step(1, 4'hB, 32'hFFFF_FFFF, 32'h1);
    step(1, 4'h8, 32'hA, 32'h5);
    // R7 shift edges
    step(1, 4'h2, 32'h8000_0001, 32'd1);
    step(1, 4'h2, 32'h0000_0001, 32'd32);
    step(1, 4'h2, 32'hFFFF_FFFF, 32'd33);
    step(1, 4'h3, 32'h8000_0000, 32'd32);
    step(1, 4'h3, 32'hFFFF_FFFF, 32'd200);
    step(1, 4'h3, 32'h0000_0003, 32'd1);
    // R8 arithmetic shift large amount
    step(1, 4'h4, 32'h8000_0000, 32'd40);
    step(1, 4'h4, 32'h4000_0000, 32'd32);
    step(1, 4'h4, 32'h8000_0010, 32'd4);
    // R9 rotate
    step(1, 4'h7, 32'h0000_000F, 32'd4);
    step(1, 4'h7, 32'h8000_0000, 32'd32);
    step(1, 4'h7, 32'h0000_0001, 32'd64);
    // R10 zero amount keeps value and C
    step(1, 4'hA, 32'h3, 32'h1);                   // C=1
    step(1, 4'h2, 32'h1234_5678, 32'hFFFF_FF00);
    step(1, 4'h3, 32'h0, 32'h0);
    // R11 idle cycles must not touch flags
    step(0, 4'hA, 32'h0, 32'h1);
    step(0, 4'h9, 32'h0, 32'h0);

    for (int k = 0; k < 4000; k++) begin
      logic [3:0] op;
      op = 4'($urandom_range(15, 0));
      step(($urandom_range(99, 0) < 85), op, $urandom, pick_src());
    end
    step(0, 4'h0, 32'h0, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule